// File: doc/BRIEF.md
# Reload PWM Timer

An 8-bit up-counter with a programmable reload value. It produces four independent pulse-width-modulated outputs, two edge-triggered capture channels and an overflow time base. The counter advances on a tick. The tick comes either from an internal power-of-two divider of the system clock or from rising edges on an external event input. When the counter passes 255, it restarts from the reload value, so the PWM period is 256 minus the reload value, in ticks.

Each PWM channel has a duty register. The duty register is copied into a private compare register only when the counter wraps. Software may therefore rewrite a duty value at any moment without disturbing the period in progress. An output is active while the counter is below its compare value. Each channel has its own enable bit and polarity bit. The capture channels copy the counter when a selected edge appears on their synchronized input. The overflow flag and the two capture flags drive a single interrupt, gated by per-source enables.

Top module: `reload_pwm_timer`

## Requirements
- R1: After reset every register, the counter, all compare registers and all flags read zero, and the outputs pwm and irq are low.
- R2: With CTRL (address 0) bit 7 clear and bit 3 (run) set, the counter advances once every 2^P clocks, where P is CTRL[6:4]. With run clear, the counter holds its value.
- R3: On a tick with the counter at 8'hFF, the counter loads the value of RELOAD (address 3) and STAT (address 1) bit 0 is set.
- R4: PWM channel x is active for the counter values below its compare value within each period from RELOAD to 8'hFF. A compare value of 8'hFF makes it active for the whole period. A compare value at or below RELOAD makes it never active.
- R5: PWMCTL (address 4) bit x enables channel x, and a disabled channel outputs 0. PWMCTL bit 4+x inverts the active level of channel x.
- R6: The duty registers DUTY0..DUTY3 (addresses 5..8) reach the compare registers only at a counter wrap. A write in the middle of a period takes effect from the next period.
- R7: With CTRL bit 7 set, only rising edges of ext_clk (synchronized through two flops) advance the counter, and the system clock alone does not. With RELOAD = 256-N, an overflow follows N events.
- R8: CAPCTL (address 9) bits [1:0] select the rising and falling edge for capture channel 0, and bits [3:2] do the same for channel 1. On a selected edge of synchronized cap_in[x], CAPx (address 10+x) takes the counter value and STAT bit 1+x is set. An edge that is not selected changes neither.
- R9: Writing 1 to a STAT bit clears that flag. Writing 0 leaves it unchanged.
- R10: irq is high exactly when a flag is set and its enable is set: CTRL bit 0 enables overflow, CAPCTL bit 4 enables capture 0, and CAPCTL bit 5 enables capture 1.
- R11: A write to CNT (address 2) loads the counter directly. rdata returns the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| ext_clk | input | 1 | External event input |
| cap_in | input | 2 | Capture inputs |
| pwm | output | 4 | PWM outputs |
| ovf_flag | output | 1 | Overflow flag |
| cap_flag | output | 2 | Capture flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that software changes the counter only through the CNT address. Any other counter step is therefore either an increment or a wrap to the reload value. The assertions also assume that the capture inputs are held long enough for the synchronizers to see each level. The stimulus holds every cap_in and ext_clk level for at least three clocks. It does all writes on falling clock edges and keeps the counter stopped while it sets up capture values, so every expected counter value is exact.

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ext_clk,
  input  logic [1:0] cap_in,
  output logic [3:0] pwm,
  output logic       ovf_flag,
  output logic [1:0] cap_flag,
  output logic       irq
);
  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_CNT = 4'd2, A_RLD = 4'd3,
                         A_PCTL = 4'd4, A_DUTY0 = 4'd5, A_CCTL = 4'd9, A_CAP0 = 4'd10;

  logic [7:0] ctrl, reload, pwmctl, capctl, cnt;
  logic [3:0][7:0] duty_v, ocr_v;
  logic [1:0][7:0] cap_v;
  logic [6:0] div;
  logic [2:0] ext_s;

  wire       run    = ctrl[3];
  wire       ext_on = ctrl[7];
  wire [6:0] mask   = 7'((8'd1 << ctrl[6:4]) - 8'd1);
  wire       tick   = run & (ext_on ? (ext_s[1] & ~ext_s[2]) : ((div & mask) == mask));
  wire       wrap   = tick & (cnt == 8'hFF);
  wire       wr_cnt = wr_en && addr == A_CNT;
  wire       wr_stat = wr_en && addr == A_STAT;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0; reload <= '0; pwmctl <= '0; capctl <= '0; duty_v <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  ctrl   <= wdata;
        A_RLD:   reload <= wdata;
        A_PCTL:  pwmctl <= wdata;
        A_CCTL:  capctl <= wdata;
        4'd5:    duty_v[0] <= wdata;
        4'd6:    duty_v[1] <= wdata;
        4'd7:    duty_v[2] <= wdata;
        4'd8:    duty_v[3] <= wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; div <= '0; ext_s <= '0; ovf_flag <= 1'b0;
    end else begin
      ext_s <= {ext_s[1:0], ext_clk};
      div   <= (run && !ext_on) ? div + 7'd1 : 7'd0;
      if (wr_cnt)    cnt <= wdata;
      else if (tick) cnt <= wrap ? reload : cnt + 8'd1;
      if (wrap)                      ovf_flag <= 1'b1;
      else if (wr_stat && wdata[0])  ovf_flag <= 1'b0;
    end

  for (genvar i = 0; i < 4; i++) begin : g_pwm
    logic [7:0] ocr_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    ocr_q <= '0;
      else if (wrap) ocr_q <= duty_v[i];
    assign ocr_v[i] = ocr_q;
    wire act = (ocr_q == 8'hFF) || (cnt < ocr_q);
    assign pwm[i] = pwmctl[i] & (act ^ pwmctl[4+i]);
  end

  for (genvar c = 0; c < 2; c++) begin : g_cap
    logic [2:0] s;
    logic [7:0] val;
    logic       flg;
    wire hit = (capctl[2*c] & s[1] & ~s[2]) | (capctl[2*c+1] & ~s[1] & s[2]);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        s <= '0; val <= '0; flg <= 1'b0;
      end else begin
        s <= {s[1:0], cap_in[c]};
        if (hit) val <= cnt;
        if (hit)                          flg <= 1'b1;
        else if (wr_stat && wdata[1+c])   flg <= 1'b0;
      end
    assign cap_v[c]    = val;
    assign cap_flag[c] = flg;
  end

  assign irq = (ovf_flag & ctrl[0]) | (cap_flag[0] & capctl[4]) | (cap_flag[1] & capctl[5]);

  always_comb
    case (addr)
      A_CTRL:     rdata = ctrl;
      A_STAT:     rdata = {5'b0, cap_flag, ovf_flag};
      A_CNT:      rdata = cnt;
      A_RLD:      rdata = reload;
      A_PCTL:     rdata = pwmctl;
      A_DUTY0:    rdata = duty_v[0];
      4'd6:       rdata = duty_v[1];
      4'd7:       rdata = duty_v[2];
      4'd8:       rdata = duty_v[3];
      A_CCTL:     rdata = capctl;
      A_CAP0:     rdata = cap_v[0];
      4'd11:      rdata = cap_v[1];
      default:    rdata = 8'h00;
    endcase
endmodule

// File: rtl/reload_pwm_timer_chk.sv
module reload_pwm_timer_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [3:0]      addr,
  input logic [7:0]      cnt,
  input logic [7:0]      reload,
  input logic            run,
  input logic [3:0][7:0] ocr_v,
  input logic            ovf_flag,
  input logic [1:0]      cap_flag,
  input logic [1:0][7:0] cap_v,
  input logic            irq
);
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en && addr == 4'd2) && cnt != $past(cnt)) |->
      (cnt == 8'($past(cnt) + 8'd1)) || ($past(cnt) == 8'hFF && cnt == $past(reload)));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run) && !$past(wr_en && addr == 4'd2)) |-> $stable(cnt));
  // R6
  ocr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ocr_v != $past(ocr_v)) |-> ($past(cnt) == 8'hFF && $past(run)));
  // R3
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(cnt) == 8'hFF);
  // R8
  cap0_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag[0]) |-> cap_v[0] == $past(cnt));
  // R8
  cap1_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag[1]) |-> cap_v[1] == $past(cnt));
  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flag || cap_flag != 2'b00));
endmodule

bind reload_pwm_timer reload_pwm_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .cnt(cnt), .reload(reload),
  .run(ctrl[3]), .ocr_v(ocr_v), .ovf_flag(ovf_flag), .cap_flag(cap_flag),
  .cap_v(cap_v), .irq(irq)
);

// File: tb/reload_pwm_timer_bench.sv
module reload_pwm_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, ext_clk = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] cap_in = '0, cap_flag;
  logic [3:0] pwm;
  logic ovf_flag, irq;
  int n_chk = 0, n_fail = 0;

  reload_pwm_timer u_reload_pwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ext_clk(ext_clk), .cap_in(cap_in), .pwm(pwm), .ovf_flag(ovf_flag),
    .cap_flag(cap_flag), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  function automatic int exp_active(input int r, input int d, input bit pol);
    int p = 256 - r;
    int a = (d == 255) ? p : ((d > r) ? d - r : 0);
    return pol ? p - a : a;
  endfunction

  task automatic run_periods(input int r, input int d, input int nd, input bit pol);
    int p = 256 - r;
    int hi;
    int other;
    logic [7:0] v;
    wr(4'd0, 8'h00); wr(4'd2, 8'hFF); wr(4'd3, 8'(r)); wr(4'd5, 8'(d));
    wr(4'd4, pol ? 8'h11 : 8'h01); wr(4'd1, 8'h07); wr(4'd0, 8'h08);
    @(posedge clk);
    hi = 0; other = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      hi += pwm[0]; other += (pwm[3:1] != 3'b000);
      if (i == 0) begin
        rd(4'd2, v); chk("R3 reload value", v, r); chk("R3 ovf flag", ovf_flag, 1);
        wr_en = 1'b1; addr = 4'd5; wdata = 8'(nd);
      end else if (i == 1) wr_en = 1'b0;
      @(posedge clk);
    end
    chk("R4/R5 active count", hi, exp_active(r, d, pol));
    chk("R5 disabled channels low", other, 0);
    hi = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk); hi += pwm[0]; @(posedge clk);
    end
    chk("R6 new duty next period", hi, exp_active(r, nd, pol));
    wr(4'd0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, x;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    for (int a = 0; a < 12; a++) begin rd(4'(a), v); chk("R1 reset register", v, 0); end
    chk("R1 pwm", pwm, 0); chk("R1 irq", irq, 0);

    // R4 R5 R6 directed corners
    run_periods(200, 255, 255, 0);
    run_periods(200, 200, 199, 0);
    run_periods(128, 160, 129, 1);
    run_periods(0, 255, 100, 1);
    // R4 R6 random
    for (int k = 0; k < 8; k++) begin
      int r = $urandom % 240;
      run_periods(r, $urandom % 256, $urandom % 256, 1'($urandom % 2));
    end

    // R2 prescaler
    for (int ps = 0; ps < 8; ps++) begin
      wr(4'd0, 8'h00); wr(4'd2, 8'h00); wr(4'd0, 8'(8'h08 | (ps << 4)));
      repeat (3 * (1 << ps)) @(posedge clk);
      @(negedge clk); rd(4'd2, v);
      chk("R2 prescaled count", v, 3);
    end
    wr(4'd0, 8'h00); rd(4'd2, x);
    repeat (10) @(negedge clk); rd(4'd2, v);
    chk("R2 stopped hold", v, x);

    // R7 external events
    wr(4'd2, 8'hFB); wr(4'd3, 8'h10); wr(4'd1, 8'h07); wr(4'd0, 8'h89);
    repeat (20) @(negedge clk); rd(4'd2, v);
    chk("R7 clock ignored", v, 8'hFB);
    for (int e = 0; e < 4; e++) begin
      ext_clk = 1'b1; repeat (3) @(negedge clk); ext_clk = 1'b0; repeat (3) @(negedge clk);
    end
    rd(4'd2, v); chk("R7 four events", v, 8'hFF); chk("R7 no ovf yet", ovf_flag, 0);
    ext_clk = 1'b1; repeat (3) @(negedge clk); ext_clk = 1'b0; repeat (3) @(negedge clk);
    rd(4'd2, v); chk("R7 wrap after five", v, 8'h10);
    chk("R7 ovf set", ovf_flag, 1); chk("R10 ovf irq", irq, 1);
    wr(4'd1, 8'h00); chk("R9 write 0 keeps", ovf_flag, 1);
    wr(4'd1, 8'h01); chk("R9 ovf cleared", ovf_flag, 0); chk("R10 irq low", irq, 0);
    wr(4'd0, 8'h00);

    // R8 R11 capture
    for (int k = 0; k < 4; k++) begin
      logic [7:0] a0 = 8'($urandom), b0 = 8'($urandom), a1 = 8'($urandom), b1 = 8'($urandom);
      wr(4'd9, 8'h11); wr(4'd2, a0);
      rd(4'd2, v); chk("R11 counter write", v, a0);
      cap_in[0] = 1'b1; repeat (4) @(negedge clk);
      rd(4'd10, v); chk("R8 cap0 rise", v, a0);
      chk("R8 cap0 flag", cap_flag[0], 1); chk("R10 cap0 irq", irq, 1);
      wr(4'd1, 8'h02); chk("R9 cap0 clear", cap_flag[0], 0);
      wr(4'd2, b0); cap_in[0] = 1'b0; repeat (4) @(negedge clk);
      rd(4'd10, v); chk("R8 fall ignored value", v, a0);
      chk("R8 fall ignored flag", cap_flag[0], 0);
      wr(4'd9, 8'h0C); wr(4'd2, a1); cap_in[1] = 1'b1; repeat (4) @(negedge clk);
      rd(4'd11, v); chk("R8 cap1 rise", v, a1);
      chk("R8 cap1 flag", cap_flag[1], 1); chk("R10 cap1 masked", irq, 0);
      wr(4'd1, 8'h04);
      wr(4'd2, b1); cap_in[1] = 1'b0; repeat (4) @(negedge clk);
      rd(4'd11, v); chk("R8 cap1 fall", v, b1);
      wr(4'd1, 8'h07);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule